// File: doc/BRIEF.md
# Ping-Pong Line Pixel Serializer

This block turns one line of monochrome pixels into a serial video bit stream. It runs on a 16 MHz clock and sends one pixel every two clock cycles, which gives 8 Mbit/s. It has two byte-wide line buffers that are used in alternation. While one buffer (the front buffer) is being sent, a renderer fills the other buffer with the next line. The buffers trade roles at the start of every line that lies inside the visible window.

An external timing source pulses `line_start` once per line and presents the line number and the field parity along with it. The block compares the line number against a programmable first line, with one value for odd fields and one for even fields. It treats the 200 lines that start there as visible. On a visible line, serial output starts a fixed number of cycles after the line pulse. The first and last byte positions of each line are always sent as black. Outside the shifting interval and on non-visible lines, the output is held at 0.

At the end of each line it sends, the block pulses a done strobe. From that point the renderer may write to the buffer that was just sent. A write to the front buffer while it is still in use does not change the buffer and latches a collision flag.

Top module: `pingpong_line_shifter`

## Requirements
- R1: Each pixel bit drives `video_out` for exactly two clock cycles. Bytes go out most significant bit first, in increasing address order from address 0 to LINE_BYTES-1.
- R2: Cycle 0 is the cycle just after the clock edge that samples `line_start` high. On a visible line, bit 7 of byte 0 appears on `video_out` during cycle 219 (START_CYC). The last bit ends after cycle 219+16*LINE_BYTES-1.
- R3: A line is visible when (`line_num` − first line) modulo 2^LINE_W is below 200. The first line is `start_odd` when `field_odd`=1 and `start_even` when `field_odd`=0. All of these are sampled on the `line_start` edge.
- R4: `video_out` is 0 on non-visible lines, before cycle 219, from cycle 219+16*LINE_BYTES on, and throughout the time slots of byte addresses 0 and LINE_BYTES-1.
- R5: `cur_buf` names the front buffer. It inverts on each `line_start` of a visible line and stays unchanged on non-visible lines.
- R6: `buf_done` is a one-cycle pulse in cycle 219+16*LINE_BYTES of every visible line. It never appears on non-visible lines.
- R7: On a visible line, from cycle 0 up to (but not including) the `buf_done` cycle, a write with `wr_buf` equal to `cur_buf` leaves the buffer unchanged. At any other time a write to either buffer takes effect.
- R8: A write that is ignored under R7 sets `collision`. The flag stays set until reset.
- R9: After reset, `video_out`, `buf_done`, `collision` and `cur_buf` are 0, and no line is visible until the next `line_start`.
- R10: On a visible line, bytes written to the back buffer (`wr_buf` != `cur_buf`) are the bytes sent on the next visible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | 10 | Line number, sampled with `line_start` |
| field_odd | input | 1 | 1 selects the odd-field first line |
| start_odd | input | 10 | First visible line of odd fields |
| start_even | input | 10 | First visible line of even fields |
| wr_en | input | 1 | Buffer write strobe |
| wr_buf | input | 1 | Buffer selected by the write |
| wr_addr | input | 6 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| video_out | output | 1 | Serial pixel output |
| buf_done | output | 1 | Pulse when the front buffer has been sent |
| cur_buf | output | 1 | Index of the front buffer |
| collision | output | 1 | Sticky flag for an ignored write to the front buffer |

## Verification
The assertions assume that `line_start` pulses no more often than once per LINE_CYCLES cycles. They also assume that no write occurs on the same edge as `line_start`. The stimulus keeps to both: it drives every line for its full 1024 cycles and places writes only inside a running line. The window start values are chosen so that each visible range fits below 2^10 without wrapping. Line numbers are picked both at the window edges and at random, so the modular comparison is exercised only inside that range.

// File: rtl/pingpong_line_shifter.sv
`timescale 1ns/1ps
module pingpong_line_shifter #(
  parameter int LINE_CYCLES  = 1024,
  parameter int START_CYC    = 219,
  parameter int LINE_BYTES   = 40,
  parameter int ACTIVE_LINES = 200,
  parameter int LINE_W       = 10,
  localparam int CW = $clog2(LINE_CYCLES),
  localparam int AW = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] start_odd,
  input  logic [LINE_W-1:0] start_even,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  output logic              video_out,
  output logic              buf_done,
  output logic              cur_buf,
  output logic              collision
);

  localparam int STOP_CYC = START_CYC + 16 * LINE_BYTES;

  logic [CW-1:0]     cnt, cnt_nx, pos;
  logic              active_r, front;
  logic [7:0]        mem [2][LINE_BYTES];
  logic [LINE_W-1:0] rel;
  logic              line_act, in_win, owned, blocked, pix;
  logic [AW-1:0]     byte_i;
  logic [2:0]        bit_i;

  assign cnt_nx   = line_start ? '0 : (cnt == CW'(LINE_CYCLES - 1)) ? cnt : cnt + CW'(1);
  assign rel      = line_num - (field_odd ? start_odd : start_even);
  assign line_act = rel < LINE_W'(ACTIVE_LINES);
  assign in_win   = active_r && !line_start &&
                    cnt_nx >= CW'(START_CYC) && cnt_nx < CW'(STOP_CYC);
  assign pos      = cnt_nx - CW'(START_CYC);
  assign byte_i   = AW'(pos >> 4);
  assign bit_i    = 3'd7 - 3'(pos >> 1);
  assign pix      = (byte_i != '0) && (byte_i != AW'(LINE_BYTES - 1)) && mem[front][byte_i][bit_i];
  assign owned    = active_r && cnt < CW'(STOP_CYC);
  assign blocked  = wr_buf == front && owned;
  assign cur_buf  = front;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= CW'(LINE_CYCLES - 1);
      active_r  <= 1'b0;
      front     <= 1'b0;
      video_out <= 1'b0;
      buf_done  <= 1'b0;
      collision <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (line_start) begin
        active_r <= line_act;
        if (line_act) front <= ~front;
      end
      video_out <= in_win && pix;
      buf_done  <= active_r && !line_start && cnt_nx == CW'(STOP_CYC);
      if (wr_en && blocked) collision <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (wr_en && !blocked) mem[wr_buf][wr_addr] <= wr_data;

  // R4
  quiet_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CW'(START_CYC)) |-> !video_out);

  // R3
  quiet_when_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_out |-> active_r);

  // R5
  swap_only_at_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(front));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !buf_done);

  // R8
  collision_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> collision);

endmodule

// File: tb/tb_pingpong_line_shifter.sv
`timescale 1ns/1ps
module tb_pingpong_line_shifter;
  localparam int NB = 40, START = 219, STOP = START + 16 * NB;
  localparam int SO = 23, SE = 336;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, line_start, field_odd, wr_en, wr_buf;
  logic [9:0] line_num, start_odd, start_even;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic video_out, buf_done, cur_buf, collision;

  pingpong_line_shifter dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .field_odd(field_odd), .start_odd(start_odd), .start_even(start_even),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
    .video_out(video_out), .buf_done(buf_done), .cur_buf(cur_buf), .collision(collision));

  int checks = 0, failures = 0;
  logic [7:0] m [2][NB];
  int frontm = 0;
  bit collm = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_vid(input int k, input bit act, input int fb);
    int j, b;
    if (!act || k < START || k >= STOP) return 0;
    j = (k - START) / 2;
    b = j / 8;
    if (b == 0 || b == NB - 1) return 0;
    return m[fb][b][7 - j % 8];
  endfunction

  function automatic bit is_visible(input int ln, input bit odd);
    int st = odd ? SO : SE;
    return ((ln - st) & 1023) < 200;
  endfunction

  task automatic run_line(input int ln, input bit odd, input bit hit_front);
    bit act = is_visible(ln, odd);
    int verr = 0, vk = -1, va = 0, ve = 0, dcnt = 0, dk = -1;
    @(negedge clk);
    line_start = 1; line_num = 10'(ln); field_odd = odd;
    @(negedge clk);
    line_start = 0;
    if (act) frontm ^= 1;
    for (int k = 0; k < 1024; k++) begin
      bit e = exp_vid(k, act, frontm);
      if (video_out !== e) begin
        if (verr == 0) begin vk = k; va = video_out; ve = e; end
        verr++;
      end
      if (buf_done) begin dcnt++; dk = k; end
      wr_en = 0;
      if (k % 37 == 5) begin
        int a = $urandom % NB;
        logic [7:0] d = 8'($urandom);
        wr_en = 1; wr_buf = 1'(frontm ^ 1); wr_addr = 6'(a); wr_data = d;
        m[frontm ^ 1][a] = d;
      end else if (hit_front && k == 500) begin
        int a = 1 + $urandom % (NB - 2);
        logic [7:0] d = ~m[frontm][a];
        wr_en = 1; wr_buf = 1'(frontm); wr_addr = 6'(a); wr_data = d;
        if (act && k < STOP) collm = 1;
        else m[frontm][a] = d;
      end
      @(negedge clk);
    end
    wr_en = 0;
    if (verr != 0) $display("  line %0d first video mismatch at cycle %0d", ln, vk);
    chk(verr == 0, "R1 R2 R3 R4 R10 video", va, ve);
    chk(act ? (dcnt == 1 && dk == STOP) : dcnt == 0, "R6 done pulse", dk, act ? STOP : -1);
    chk(cur_buf == 1'(frontm), "R5 cur_buf", cur_buf, frontm);
    chk(collision == collm, "R7 R8 collision", collision, collm);
  endtask

  initial begin
    #(5.0 * 300000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; line_start = 0; line_num = 0; field_odd = 0;
    start_odd = 10'(SO); start_even = 10'(SE);
    wr_en = 0; wr_buf = 0; wr_addr = 0; wr_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9
    chk(video_out == 0 && buf_done == 0 && collision == 0 && cur_buf == 0,
        "R9 reset outputs", {video_out, buf_done, collision, cur_buf}, 0);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < NB; a++) begin
        logic [7:0] d = (a == 3) ? 8'h80 : (a == 4) ? 8'h01 : 8'($urandom);
        wr_en = 1; wr_buf = 1'(b); wr_addr = 6'(a); wr_data = d;
        m[b][a] = d;
        @(negedge clk);
      end
    wr_en = 0;
    @(negedge clk);
    chk(video_out == 0 && cur_buf == 0, "R9 idle after reset", video_out, 0);

    run_line(5, 1, 0);      // R3 hidden line
    run_line(SO - 1, 1, 1); // R3 just before window; R7 front write allowed
    run_line(SO, 1, 0);     // R2 first visible
    for (int i = 1; i < 6; i++) run_line(SO + i, 1, i == 3); // R8 collision on one
    run_line(SO + 199, 1, 0);
    run_line(SO + 200, 1, 1);
    run_line(SE - 1, 0, 0);
    run_line(SE, 0, 0);
    run_line(SE + 199, 0, 1);
    run_line(SE + 200, 0, 0);
    for (int i = 0; i < 12; i++) begin
      bit odd = 1'($urandom);
      int ln = $urandom % 1024;
      run_line(ln, odd, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule